// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of a memory read or write burst. A one-cycle start pulse captures an 8-bit start column, a burst length code and an ordering choice. From the next clock onward the block presents one column per clock, together with a valid flag and a flag that marks the final beat of a fixed-length burst.

Two orderings are supported. Sequential ordering counts upward inside the aligned block that the burst length defines and wraps within it. Interleaved ordering forms each column by XORing the beat number into the low bits of the start column. A full-page length runs sequentially through the whole 256-column row, wrapping modulo 256, until a stop pulse ends it. A stop pulse ends any burst, and a new start replaces the running burst on any cycle, because consecutive column commands may be one clock apart.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o, last_o and err_o are low.
- R2: In the cycle after start_i is sampled high, valid_o is high and col_o equals the sampled start_col_i.
- R3: len_code_i values 0, 1, 2 and 3 give fixed bursts of 1, 2, 4 and 8 beats; valid_o stays high for exactly that many consecutive cycles unless stopped or restarted.
- R4: With order_i = 0 (sequential), beat k carries the low log2(length) bits of start_col_i plus k, modulo the length, and the upper bits unchanged.
- R5: With order_i = 1 (interleaved), beat k carries the low log2(length) bits of start_col_i XOR k, and the upper bits unchanged.
- R6: len_code_i values 4 to 7 select full page: beat k is start_col_i plus k modulo 256, and the burst continues without end until a stop or a new start.
- R7: last_o is high on the final beat of a fixed-length burst only, and never during a full-page burst.
- R8: A stop_i pulse with start_i low makes valid_o and last_o low from the next cycle; if start_i and stop_i are high together, the start wins.
- R9: A start_i pulse during a burst replaces it: the next cycle shows beat 0 of the new burst.
- R10: A full-page request with interleaved ordering runs as a sequential full-page burst and raises err_o from the next cycle until the next start; any other start clears err_o.
- R11: len_code_i, order_i and start_col_i are sampled only at start; changing them during a burst has no effect on the columns produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or interrupt pulse: load a new burst |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Length code: 0..3 give 1,2,4,8 beats; 4..7 full page |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst stop pulse |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | col_o carries a burst beat |
| last_o | output | 1 | Current beat is the last of a fixed-length burst |
| err_o | output | 1 | Interleaved full page was requested and demoted |

## Verification
A wrong beat counter or captured mask shows up on col_o one cycle after the bad value forms, since the column is a pure function of the captured start column and the beat count; directed bursts with unaligned start columns expose a wrong wrap point at the first beat that crosses the block boundary. A miscounted burst length shows up as valid_o lasting one beat too long or too short, and last_o landing on the wrong beat, within at most eight cycles of the start. Stop, interrupt and the start-beats-stop priority each show on the very next cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;

   // Length codes at or below this value are fixed power-of-two bursts
   localparam int unsigned FIX_CODE_MAX = 3;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
   parameter int unsigned COL_W = 8,
   parameter int unsigned LEN_W = 3
) (
   input  logic [LEN_W-1:0] len_code_i,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o
);
   import bcg_pkg::*;

   assign full_o = (len_code_i > LEN_W'(FIX_CODE_MAX));

   // Bit i of the wrap mask is set when the burst spans more than 2**i columns
   for (genvar i = 0; i < COL_W; i++) begin : g_mask
      if (i < int'(FIX_CODE_MAX)) begin : g_fix
         assign mask_o[i] = full_o | (len_code_i > LEN_W'(i));
      end else begin : g_page
         assign mask_o[i] = full_o;
      end
   end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl #(
   parameter int unsigned COL_W = 8,
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic             order_i,
   input  logic [COL_W-1:0] mask_d,
   input  logic             full_d,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o,
   output logic             ilv_o,
   output logic             err_o
);
   import bcg_pkg::*;

   logic at_end;
   assign at_end = !full_o && (beat_o == mask_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         beat_o   <= '0;
         base_o   <= '0;
         mask_o   <= '0;
         full_o   <= 1'b0;
         ilv_o    <= 1'b0;
         err_o    <= 1'b0;
      end else if (start_i) begin
         active_o <= 1'b1;
         beat_o   <= '0;
         base_o   <= start_col_i;
         mask_o   <= mask_d;
         full_o   <= full_d;
         ilv_o    <= (order_e'(order_i) == ORD_ILV) && !full_d;
         err_o    <= (order_e'(order_i) == ORD_ILV) && full_d;
      end else if (stop_i) begin
         active_o <= 1'b0;
      end else if (active_o) begin
         if (at_end) begin
            active_o <= 1'b0;
         end else begin
            beat_o <= beat_o + COL_W'(1);
         end
      end
   end
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] sum;
   assign sum = base_i + beat_i;

   // Per bit: inside the wrap mask take the ordered bit, outside keep the base
   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      logic ordered;
      assign ordered  = ilv_i ? (base_i[i] ^ beat_i[i]) : sum[i];
      assign col_o[i] = mask_i[i] ? ordered : base_i[i];
   end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
   parameter int unsigned COL_W = 8,
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [LEN_W-1:0] len_code_i,
   input  logic             order_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             err_o
);
   import bcg_pkg::*;

   if (COL_W < FIX_CODE_MAX) begin : g_bad_col_w
      $error("COL_W must cover the longest fixed burst");
   end
   if ((2 ** LEN_W) <= (FIX_CODE_MAX + 1)) begin : g_bad_len_w
      $error("LEN_W must leave room for a full-page code");
   end

   logic [COL_W-1:0] mask_d, mask_q, beat_q, base_q;
   logic             full_d, full_q, ilv_q, active_q;

   bcg_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W)) u_dec (
      .len_code_i (len_code_i),
      .mask_o     (mask_d),
      .full_o     (full_d)
   );

   bcg_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .start_col_i (start_col_i),
      .order_i     (order_i),
      .mask_d      (mask_d),
      .full_d      (full_d),
      .active_o    (active_q),
      .beat_o      (beat_q),
      .base_o      (base_q),
      .mask_o      (mask_q),
      .full_o      (full_q),
      .ilv_o       (ilv_q),
      .err_o       (err_o)
   );

   bcg_addr #(.COL_W(COL_W)) u_addr (
      .base_i (base_q),
      .beat_i (beat_q),
      .mask_i (mask_q),
      .ilv_i  (ilv_q),
      .col_o  (col_o)
   );

   assign valid_o = active_q;
   assign last_o  = active_q && !full_q && (beat_q == mask_q);
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
   parameter int unsigned COL_W = 8,
   parameter int unsigned LEN_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [LEN_W-1:0] len_code_i,
   input logic             order_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             err_o
);
   a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (!valid_o && !last_o));

   a_r7_last_is_final: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   a_r3_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !stop_i) |=> valid_o);

   a_r10_err_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (err_o == $past(order_i && (len_code_i > LEN_W'(3)))));

   a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(err_o));
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W), .LEN_W(LEN_W)) u_bcg_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .len_code_i  (len_code_i),
   .order_i     (order_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .err_o       (err_o)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       order_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       valid_o, last_o, err_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   burst_col_gen u_burst_col_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                          input logic ilv, input int k);
      logic [7:0] m, low;
      m   = (code >= 3'd4) ? 8'hFF : ((8'd1 << code) - 8'd1);
      low = (ilv && code < 3'd4) ? (s ^ k[7:0]) : (s + k[7:0]);
      return (s & ~m) | (low & m);
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic issue(input logic [7:0] s, input logic [2:0] code, input logic ilv);
      start_col_i = s; len_code_i = code; order_i = ilv; start_i = 1'b1;
      step();
      start_i = 1'b0;
   endtask

   // Check beats first..first+n-1 of a burst; cursor left on the beat after
   task automatic beats(input string req, input logic [7:0] s, input logic [2:0] code,
                        input logic ilv, input int first, input int n, input int len);
      for (int k = first; k < first + n; k++) begin
         check({req, " col"}, col_o, exp_col(s, code, ilv, k));
         check({req, " valid"}, valid_o, 1);
         check({req, " last"}, last_o, (len > 0 && k == len - 1) ? 1 : 0);
         step();
      end
   endtask

   task automatic t_reset();
      check("R1 valid", valid_o, 0);
      check("R1 last", last_o, 0);
      check("R1 err", err_o, 0);
   endtask

   task automatic t_fixed(input logic [7:0] s, input logic [2:0] code, input logic ilv);
      int len = 1 << code;
      issue(s, code, ilv);
      check("R2 first col", col_o, s);
      beats(ilv ? "R5 ilv" : "R4 seq", s, code, ilv, 0, len, len);
      check("R3 ends after length", valid_o, 0);
      check("R7 last low after", last_o, 0);
      check("R10 err low", err_o, 0);
   endtask

   task automatic t_full(input logic ilv);
      issue(8'hFC, 3'd7, ilv);
      check("R10 err flag", err_o, ilv ? 1 : 0);
      beats("R6 full page", 8'hFC, 3'd7, 1'b0, 0, 10, 0);
      stop_i = 1'b1; step(); stop_i = 1'b0;
      check("R8 stop valid", valid_o, 0);
      check("R8 stop last", last_o, 0);
      check("R10 err held", err_o, ilv ? 1 : 0);
   endtask

   task automatic t_interrupt();
      issue(8'h10, 3'd3, 1'b0);
      beats("R9 before", 8'h10, 3'd3, 1'b0, 0, 3, 8);
      issue(8'h83, 3'd1, 1'b0);
      beats("R9 new burst", 8'h83, 3'd1, 1'b0, 0, 2, 2);
      check("R9 ends", valid_o, 0);
   endtask

   task automatic t_start_beats_stop();
      issue(8'h20, 3'd3, 1'b0);
      beats("R8 pre", 8'h20, 3'd3, 1'b0, 0, 2, 8);
      stop_i = 1'b1;
      issue(8'h47, 3'd2, 1'b1);
      stop_i = 1'b0;
      beats("R8 start wins", 8'h47, 3'd2, 1'b1, 0, 4, 4);
      check("R8 ends", valid_o, 0);
   endtask

   task automatic t_sampled_once();
      issue(8'h5B, 3'd3, 1'b1);
      start_col_i = 8'h00; len_code_i = 3'd0; order_i = 1'b0;
      beats("R11 inputs ignored", 8'h5B, 3'd3, 1'b1, 0, 8, 8);
      check("R11 ends", valid_o, 0);
   endtask

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_fixed(8'h3D, 3'd0, 1'b0);
      t_fixed(8'h3D, 3'd1, 1'b0);
      t_fixed(8'h3D, 3'd2, 1'b0);
      t_fixed(8'h3D, 3'd3, 1'b0);
      t_fixed(8'h5B, 3'd2, 1'b1);
      t_fixed(8'h5B, 3'd3, 1'b1);
      t_full(1'b0);
      t_full(1'b1);
      t_fixed(8'h07, 3'd1, 1'b0);
      t_interrupt();
      t_start_beats_stop();
      t_sampled_once();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule